// File: doc/BRIEF.md
# Sticky Event Status Field

This block is one hardware status field of a control register. It watches a multi-bit trigger vector from the surrounding logic and turns events on that vector into status bits that stay set until software clears them. The field value also drives two single-bit outputs, an interrupt line and a halt line. Each line is qualified by its own gate vector, and that vector acts either as a mask or as an enable.

Two inputs select how events are found and how they are stored. The detection mode picks one of four conditions per bit: level, rising edge, falling edge, or either edge. Each is judged against a copy of the trigger delayed by one cycle. The capture mode picks one of three behaviours. In per-bit mode each bit is set and held on its own. In whole-value mode the complete trigger word is loaded, but only while the field is empty. In plain mode the field just follows the trigger. Software clears bits by writing ones to them and reads the field value directly.

Top module: `stickyField`

## Requirements
- R1: Reset is sampled on the rising clock edge and is active when `rstIn` equals 0 (parameter `RST_ACTIVE_LOW`=1; with 0 the active level is 1). In the cycle after a reset edge, `fieldVal` is zero and `intOut` and `haltOut` are low. The delayed trigger copy is also zeroed, so a trigger that is high in the first cycle after reset counts as a rising edge.
- R2: `detMode` encodes the per-bit event condition against the trigger sampled one edge earlier (D): 0 = level (trigger bit is 1), 1 = rising (D=0, trigger=1), 2 = falling (D=1, trigger=0), 3 = either edge.
- R3: With `capMode` 1 or 3 (per-bit), every field bit whose event condition is true becomes 1 at the next edge, and every bit that is 1 stays 1 until software clears it.
- R4: In `capMode` 1, 2 and 3, a write (`swWrEn`=1) clears at the next edge each field bit where `swWrData` is 1 and leaves the bits where it is 0 unchanged. `fieldVal` always shows the current field value.
- R5: In per-bit mode, when an event and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R6: With `capMode`=2 (whole-value), the field loads the whole current trigger word at the next edge when any bit has an event and the field is all zeros; a software write in that cycle has no effect. Otherwise the field keeps its value, apart from R4 clears.
- R7: In whole-value mode with edge detection, an edge on any single bit of the word is enough to trigger the load of the full word, including bits that had no edge.
- R8: With `capMode`=0 (plain), `fieldVal` equals the trigger sampled at the previous edge, and software writes have no effect.
- R9: `intOut` is the OR of all bits of `fieldVal & ~intGate` when `intGateEn`=0 (mask), or of `fieldVal & intGate` when `intGateEn`=1 (enable). It follows `fieldVal` and the gate inputs in the same cycle.
- R10: `haltOut` is formed from `haltGate` and `haltGateEn` with the same mask/enable rule as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstIn | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_LOW` |
| trigIn | input | WIDTH | Hardware event vector |
| detMode | input | 2 | Event detection mode (R2) |
| capMode | input | 2 | Capture mode: 0 plain, 1/3 per-bit, 2 whole-value |
| intGate | input | WIDTH | Interrupt mask or enable vector |
| intGateEn | input | 1 | 1: `intGate` is an enable, 0: a mask |
| haltGate | input | WIDTH | Halt mask or enable vector |
| haltGateEn | input | 1 | 1: `haltGate` is an enable, 0: a mask |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | WIDTH | Write-one-to-clear data |
| fieldVal | output | WIDTH | Current field value (software read data) |
| intOut | output | 1 | OR-reduced gated interrupt |
| haltOut | output | 1 | OR-reduced gated halt |

## Verification
The hold and snapshot assertions assume that `capMode` does not change between the cycle they sample and the next one. The stimulus therefore changes the mode only at phase boundaries and keeps each mode for several cycles. The gate inputs, write data and trigger are unconstrained within a phase. The bench sets up the same-cycle set and clear collision on purpose. It also drives a single-bit edge on a word whose other bits are high, so the whole-value load is tested with bits that had no edge.

// File: rtl/stickyPkg.sv
package stickyPkg;
  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } detMode_e;

  typedef enum logic [1:0] {
    CAP_PLAIN = 2'd0,
    CAP_BIT   = 2'd1,
    CAP_WORD  = 2'd2,
    CAP_BIT2  = 2'd3
  } capMode_e;

  typedef struct packed {
    logic plainLoad;
    logic wordLoad;
    logic bitMerge;
    logic swClear;
  } fieldStrobe_t;
endpackage

// File: rtl/stickyGate.sv
module stickyGate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] fieldIn,
  input  logic [WIDTH-1:0] gateVec,
  input  logic             gateIsEnable,
  output logic             lineOut
);
  logic [WIDTH-1:0] passVec;

  always_comb begin
    passVec = gateIsEnable ? (fieldIn & gateVec) : (fieldIn & ~gateVec);
    lineOut = |passVec;
  end
endmodule

// File: rtl/stickyCtrl.sv
module stickyCtrl
  import stickyPkg::*;
(
  input  capMode_e     capMode,
  input  logic         anyEvt,
  input  logic         fieldEmpty,
  input  logic         swWrEn,
  output fieldStrobe_t strobe
);
  logic isPlain;
  logic isWord;

  always_comb begin
    isPlain          = (capMode == CAP_PLAIN);
    isWord           = (capMode == CAP_WORD);
    strobe.plainLoad = isPlain;
    strobe.wordLoad  = isWord && anyEvt && fieldEmpty;
    strobe.bitMerge  = (capMode == CAP_BIT) || (capMode == CAP_BIT2);
    strobe.swClear   = swWrEn && !isPlain && !strobe.wordLoad;
  end
endmodule

// File: rtl/stickyDatapath.sv
module stickyDatapath
  import stickyPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstAct,
  input  logic [WIDTH-1:0] trigIn,
  input  detMode_e         detMode,
  input  fieldStrobe_t     strobe,
  input  logic [WIDTH-1:0] swWrData,
  input  logic [WIDTH-1:0] intGate,
  input  logic             intGateEn,
  input  logic [WIDTH-1:0] haltGate,
  input  logic             haltGateEn,
  output logic [WIDTH-1:0] fieldQ,
  output logic             anyEvt,
  output logic             fieldEmpty,
  output logic             intOut,
  output logic             haltOut
);
  localparam logic [WIDTH-1:0] ZERO_VEC = '0;

  logic [WIDTH-1:0] trigDly;
  logic [WIDTH-1:0] evtVec;
  logic [WIDTH-1:0] clrVec;
  logic [WIDTH-1:0] fieldNxt;

  for (genvar b = 0; b < WIDTH; b++) begin : g_evt
    always_comb begin
      unique case (detMode)
        DET_LEVEL: evtVec[b] = trigIn[b];
        DET_RISE:  evtVec[b] = !trigDly[b] && trigIn[b];
        DET_FALL:  evtVec[b] = trigDly[b] && !trigIn[b];
        default:   evtVec[b] = trigDly[b] ^ trigIn[b];
      endcase
    end
  end

  always_comb begin
    anyEvt     = |evtVec;
    fieldEmpty = (fieldQ == ZERO_VEC);
    clrVec     = strobe.swClear ? swWrData : ZERO_VEC;
    if (strobe.plainLoad || strobe.wordLoad) begin
      fieldNxt = trigIn;
    end else if (strobe.bitMerge) begin
      fieldNxt = (fieldQ & ~clrVec) | evtVec;
    end else begin
      fieldNxt = fieldQ & ~clrVec;
    end
  end

  always_ff @(posedge clk) begin
    if (rstAct) begin
      trigDly <= ZERO_VEC;
      fieldQ  <= ZERO_VEC;
    end else begin
      trigDly <= trigIn;
      fieldQ  <= fieldNxt;
    end
  end

  stickyGate #(.WIDTH(WIDTH)) i_intGate (
    .fieldIn     (fieldQ),
    .gateVec     (intGate),
    .gateIsEnable(intGateEn),
    .lineOut     (intOut)
  );

  stickyGate #(.WIDTH(WIDTH)) i_haltGate (
    .fieldIn     (fieldQ),
    .gateVec     (haltGate),
    .gateIsEnable(haltGateEn),
    .lineOut     (haltOut)
  );
endmodule

// File: rtl/stickyField.sv
module stickyField
  import stickyPkg::*;
#(
  parameter int WIDTH          = 8,
  parameter bit RST_ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rstIn,
  input  logic [WIDTH-1:0] trigIn,
  input  logic [1:0]       detMode,
  input  logic [1:0]       capMode,
  input  logic [WIDTH-1:0] intGate,
  input  logic             intGateEn,
  input  logic [WIDTH-1:0] haltGate,
  input  logic             haltGateEn,
  input  logic             swWrEn,
  input  logic [WIDTH-1:0] swWrData,
  output logic [WIDTH-1:0] fieldVal,
  output logic             intOut,
  output logic             haltOut
);
  logic         rstAct;
  logic         anyEvt;
  logic         fieldEmpty;
  fieldStrobe_t strobe;

  assign rstAct = RST_ACTIVE_LOW ? !rstIn : rstIn;

  stickyCtrl i_ctrl (
    .capMode   (capMode_e'(capMode)),
    .anyEvt    (anyEvt),
    .fieldEmpty(fieldEmpty),
    .swWrEn    (swWrEn),
    .strobe    (strobe)
  );

  stickyDatapath #(.WIDTH(WIDTH)) i_dp (
    .clk       (clk),
    .rstAct    (rstAct),
    .trigIn    (trigIn),
    .detMode   (detMode_e'(detMode)),
    .strobe    (strobe),
    .swWrData  (swWrData),
    .intGate   (intGate),
    .intGateEn (intGateEn),
    .haltGate  (haltGate),
    .haltGateEn(haltGateEn),
    .fieldQ    (fieldVal),
    .anyEvt    (anyEvt),
    .fieldEmpty(fieldEmpty),
    .intOut    (intOut),
    .haltOut   (haltOut)
  );
endmodule

// File: rtl/stickyFieldChk.sv
module stickyFieldChk #(
  parameter int WIDTH          = 8,
  parameter bit RST_ACTIVE_LOW = 1'b1
) (
  input logic             clk,
  input logic             rstIn,
  input logic [WIDTH-1:0] trigIn,
  input logic [1:0]       capMode,
  input logic             swWrEn,
  input logic [WIDTH-1:0] fieldVal,
  input logic             intOut,
  input logic             haltOut
);
  logic rstAct;
  assign rstAct = RST_ACTIVE_LOW ? !rstIn : rstIn;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rstAct |=> (fieldVal == '0 && !intOut && !haltOut)); // R1

  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (rstAct)
    ((capMode == 2'd1 || capMode == 2'd3) && !swWrEn)
      |=> ((fieldVal & $past(fieldVal)) == $past(fieldVal))); // R3

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rstAct)
    (capMode == 2'd2 && fieldVal != '0 && !swWrEn) |=> $stable(fieldVal)); // R6

  AST_PLAIN_FOLLOWS: assert property (@(posedge clk) disable iff (rstAct)
    (capMode == 2'd0) |=> (fieldVal == $past(trigIn))); // R8

  AST_INT_NEEDS_FIELD: assert property (@(posedge clk) disable iff (rstAct)
    intOut |-> (fieldVal != '0)); // R9

  AST_HALT_NEEDS_FIELD: assert property (@(posedge clk) disable iff (rstAct)
    haltOut |-> (fieldVal != '0)); // R10
endmodule

bind stickyField stickyFieldChk #(.WIDTH(WIDTH), .RST_ACTIVE_LOW(RST_ACTIVE_LOW)) i_chk (
  .clk     (clk),
  .rstIn   (rstIn),
  .trigIn  (trigIn),
  .capMode (capMode),
  .swWrEn  (swWrEn),
  .fieldVal(fieldVal),
  .intOut  (intOut),
  .haltOut (haltOut)
);

// File: tb/test_stickyField.sv
`timescale 1ns/1ps
module test_stickyField;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstIn = 1'b0;
  logic [W-1:0] trigIn = '0;
  logic [1:0]   detMode = 2'd0;
  logic [1:0]   capMode = 2'd1;
  logic [W-1:0] intGate = '0;
  logic         intGateEn = 1'b0;
  logic [W-1:0] haltGate = '0;
  logic         haltGateEn = 1'b0;
  logic         swWrEn = 1'b0;
  logic [W-1:0] swWrData = '0;
  logic [W-1:0] fieldVal;
  logic         intOut;
  logic         haltOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  logic [W-1:0] refField = '0;
  logic [W-1:0] refDly = '0;

  always #5 clk = ~clk;

  stickyField #(.WIDTH(W)) i_stickyField (
    .clk(clk), .rstIn(rstIn), .trigIn(trigIn), .detMode(detMode), .capMode(capMode),
    .intGate(intGate), .intGateEn(intGateEn), .haltGate(haltGate), .haltGateEn(haltGateEn),
    .swWrEn(swWrEn), .swWrData(swWrData), .fieldVal(fieldVal), .intOut(intOut), .haltOut(haltOut)
  );

  function automatic logic gateLine(logic [W-1:0] f, logic [W-1:0] g, logic en);
    return en ? |(f & g) : |(f & ~g);
  endfunction

  // Behavioural model: applied once per rising edge with the inputs driven before it.
  always @(posedge clk) begin
    logic [W-1:0] ev;
    if (!rstIn) begin
      refField = '0;
      refDly   = '0;
    end else begin
      for (int b = 0; b < W; b++) begin
        case (detMode)
          2'd0: ev[b] = trigIn[b];
          2'd1: ev[b] = !refDly[b] && trigIn[b];
          2'd2: ev[b] = refDly[b] && !trigIn[b];
          default: ev[b] = refDly[b] != trigIn[b];
        endcase
      end
      if (capMode == 2'd0) refField = trigIn;
      else if (capMode == 2'd2) begin
        if (ev != 0 && refField == 0) refField = trigIn;
        else if (swWrEn) refField = refField & ~swWrData;
      end else begin
        if (swWrEn) refField = refField & ~swWrData;
        refField = refField | ev;
      end
      refDly = trigIn;
    end
  end

  task automatic compareAll(string tag);
    logic expInt, expHalt;
    expInt  = gateLine(refField, intGate, intGateEn);
    expHalt = gateLine(refField, haltGate, haltGateEn);
    checks++;
    if (fieldVal !== refField) begin
      errors++;
      $display("FAIL %s fieldVal actual=%h expected=%h", tag, fieldVal, refField);
    end
    checks++;
    if (intOut !== expInt) begin
      errors++;
      $display("FAIL %s intOut actual=%b expected=%b", tag, intOut, expInt);
    end
    checks++;
    if (haltOut !== expHalt) begin
      errors++;
      $display("FAIL %s haltOut actual=%b expected=%b", tag, haltOut, expHalt);
    end
  endtask

  // Compare every cycle against the model, away from the active edge.
  always @(negedge clk) if (!finished) compareAll(curTag);

  task automatic expectField(string tag, logic [W-1:0] exp);
    checks++;
    if (fieldVal !== exp) begin
      errors++;
      $display("FAIL %s directed fieldVal actual=%h expected=%h", tag, fieldVal, exp);
    end
  endtask

  // Drive inputs after a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic cycleIn(logic [W-1:0] t, logic we, logic [W-1:0] wd);
    trigIn = t; swWrEn = we; swWrData = wd;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    // R1: reset
    curTag = "R1";
    trigIn = 8'hFF; capMode = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    expectField("R1", 8'h00);
    checks++;
    if (intOut !== 1'b0 || haltOut !== 1'b0) begin
      errors++;
      $display("FAIL R1 lines actual=%b%b expected=00", intOut, haltOut);
    end
    trigIn = 8'h01; capMode = 2'd1; detMode = 2'd1;
    rstIn = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    expectField("R1", 8'h01); // trigger high right after reset counts as rising

    // R2: detection modes in per-bit capture
    curTag = "R2";
    cycleIn(8'h01, 1'b1, 8'hFF);
    expectField("R2", 8'h00); // steady high: no rising edge
    detMode = 2'd2;
    cycleIn(8'h00, 1'b0, 8'h00);
    expectField("R2", 8'h01); // falling edge on bit 0
    detMode = 2'd3;
    cycleIn(8'h10, 1'b1, 8'h01);
    expectField("R2", 8'h10);
    detMode = 2'd0;
    cycleIn(8'h24, 1'b0, 8'h00);
    expectField("R2", 8'h34);

    // R3/R4: hold and write-one-to-clear
    curTag = "R3";
    cycleIn(8'h00, 1'b0, 8'h00);
    expectField("R3", 8'h34);
    curTag = "R4";
    cycleIn(8'h00, 1'b1, 8'h14);
    expectField("R4", 8'h20);

    // R5: set beats clear on the same bit
    curTag = "R5";
    cycleIn(8'h01, 1'b1, 8'h21);
    expectField("R5", 8'h01);

    // R6/R7: whole-value capture
    curTag = "R6";
    capMode = 2'd2; detMode = 2'd1;
    cycleIn(8'h01, 1'b1, 8'hFF); // no edge, clear empties field
    expectField("R6", 8'h00);
    cycleIn(8'h03, 1'b0, 8'h00);
    expectField("R6", 8'h03);
    cycleIn(8'h83, 1'b0, 8'h00); // edge, but field not empty
    expectField("R6", 8'h03);
    cycleIn(8'h00, 1'b1, 8'h03);
    expectField("R6", 8'h00);
    curTag = "R7";
    cycleIn(8'h7E, 1'b0, 8'h00);
    expectField("R7", 8'h7E);
    cycleIn(8'h7E, 1'b1, 8'hFF);
    expectField("R7", 8'h00);
    cycleIn(8'hFE, 1'b0, 8'h00); // only bit 7 rises, whole word loads
    expectField("R7", 8'hFE);

    // R8: plain follow, writes ignored
    curTag = "R8";
    capMode = 2'd0;
    cycleIn(8'h5A, 1'b1, 8'hFF);
    expectField("R8", 8'h5A);
    cycleIn(8'h00, 1'b1, 8'hFF);
    expectField("R8", 8'h00);

    // R9/R10: gate as mask and as enable
    curTag = "R9";
    cycleIn(8'h08, 1'b0, 8'h00);
    intGate = 8'h08; intGateEn = 1'b0; haltGate = 8'h08; haltGateEn = 1'b1;
    #1;
    checks++;
    if (intOut !== 1'b0) begin errors++; $display("FAIL R9 masked intOut actual=%b expected=0", intOut); end
    curTag = "R10";
    checks++;
    if (haltOut !== 1'b1) begin errors++; $display("FAIL R10 enabled haltOut actual=%b expected=1", haltOut); end
    intGateEn = 1'b1; haltGateEn = 1'b0;
    #1;
    checks++;
    if (intOut !== 1'b1 || haltOut !== 1'b0) begin
      errors++;
      $display("FAIL R9 R10 lines actual=%b%b expected=10", intOut, haltOut);
    end

    // Random phases, each mode held for a stretch
    for (int p = 0; p < 40; p++) begin
      capMode = 2'($urandom_range(0, 3));
      detMode = 2'($urandom_range(0, 3));
      case (capMode)
        2'd0: curTag = "R8";
        2'd2: curTag = "R6";
        default: curTag = "R3";
      endcase
      for (int c = 0; c < 25; c++) begin
        intGate = W'($urandom); intGateEn = 1'($urandom);
        haltGate = W'($urandom); haltGateEn = 1'($urandom);
        cycleIn(W'($urandom & $urandom), 1'($urandom_range(0, 3) == 0), W'($urandom));
      end
    end
    finish();
  end
endmodule